// File: doc/BRIEF.md
# Read-Delay Window Calibration Engine

This block is a hardware sequencer that tunes the read-capture delay of a two-phase DRAM PHY without processor help. Once started, it takes software control of the PHY and sweeps a small delay code for each phase. For every trial value it does four things in turn: it drives the code onto that phase's delay output, pulses a clear strobe toward the PHY's sticky burst-detect flags, issues a fixed batch of word reads, and then inspects the flag of the phase under test.

For each phase it first finds the lowest passing code. It then climbs from one above that code until the flag drops, which gives the highest passing code. Each phase then receives the integer centre of its window. If a window has no edge inside the code range, the run aborts with an error code and the delay outputs return to a built-in default profile. Completion is signalled by a single-cycle done pulse, which carries the result code.

Top module: `rdcal_engine`

## Requirements
- R1: During and right after reset, `dly_o` holds the default profile (phase 0 = 1, phase 1 = 5 with default parameters), and `busy_o`, `done_o`, `sw_ctrl_o`, `rd_valid_o` and `bd_clr_o` are low, with `err_o` = 0.
- R2: Each trial puts the trial code on the tested phase's field of `dly_o` (phase p occupies bits [3p+2:3p]), then raises `bd_clr_o` for one cycle, then completes exactly READS (128) accepted reads (`rd_valid_o` and `rd_ready_i` both high), and only then samples `bd_i`. `dly_o` does not change while reads are outstanding.
- R3: The minimum search for a phase tries codes 0, 1, 2, … and stops at the first code whose flag bit (bit p of `bd_i` for phase p) is set. That code is the phase minimum. If code 7 is tried with the flag clear, the run ends with `err_o` = 2.
- R4: The maximum search for a phase starts at minimum+1 and stops at the first code whose flag is clear; the maximum is that code minus 1. If code 7 is tried with the flag still set, the run ends with `err_o` = 2. If the minimum is 7, no maximum trials are run and the maximum is 7.
- R5: The searches run in this order: minimum of phase 0, minimum of phase 1, maximum of phase 0, maximum of phase 1.
- R6: On success, `err_o` = 0 and each phase field of `dly_o` holds floor((min+max)/2). These values are present when `done_o` pulses.
- R7: On a failed search, no further trials are run, `err_o` = 2, and `dly_o` holds the default profile when `done_o` pulses.
- R8: `done_o` is high for exactly one cycle per accepted start, and `busy_o` is low in that cycle.
- R9: A `start_i` pulse while `busy_o` is high has no effect: the trial sequence is unchanged and only one done pulse follows.
- R10: `sw_ctrl_o` is high from the cycle after a start is accepted through the last trial, and low in the done cycle.
- R11: Once `rd_valid_o` is raised, it stays high until `rd_ready_i` accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start calibration (accepted when not busy) |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result code: 0 success, 2 window edge not found |
| sw_ctrl_o | output | 1 | Selects software/injector control of the PHY |
| rd_valid_o | output | 1 | Read request toward memory |
| rd_ready_i | input | 1 | Memory accepts the current read request |
| bd_i | input | NPHASE | Sticky burst-detect flags, bit p for phase p |
| bd_clr_o | output | 1 | Clear strobe for the burst-detect flags |
| dly_o | output | NPHASE*DLY_W | Per-phase read delay codes, phase p at [p*DLY_W +: DLY_W] |

## Verification
A wrong trial counter or phase pointer shows up at the next clear strobe. At that moment the delay field of the tested phase no longer matches the code expected for the sweep, so the fault appears within a single trial of the mistake. A miscounted read batch shows when the next strobe or the done pulse arrives, as a number of accepted reads other than 128. Corrupted minimum or maximum records stay hidden until completion, and then appear as wrong centre codes or a wrong result code in the done cycle. The windows tested include ones at the bottom edge, at the top edge, with no passing code at all, and with a single passing code. Separate runs make the error appear in the minimum search and in the maximum search.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CLEAR,
    ST_READ,
    ST_SAMPLE,
    ST_NEXT,
    ST_FINISH,
    ST_DONE
  } cal_state_t;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_DLY_MAX = 2'd2;

  // Centre of a window [lo, hi], truncated toward zero; codes up to 8 bits.
  function automatic logic [7:0] win_centre(input logic [7:0] lo, input logic [7:0] hi);
    logic [8:0] sum;
    sum = {1'b0, lo} + {1'b0, hi};
    return sum[8:1];
  endfunction

endpackage

// File: rtl/rdcal_reader.sv
module rdcal_reader #(
  parameter int READS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic rd_ready_i,
  output logic rd_valid_o,
  output logic batch_done_o
);
  localparam int CW = (READS > 1) ? $clog2(READS) : 1;

  logic [CW-1:0] cnt_q;
  logic          fire;

  assign rd_valid_o   = go_i;
  assign fire         = go_i && rd_ready_i;
  assign batch_done_o = fire && (cnt_q == CW'(READS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!go_i)        cnt_q <= '0;
    else if (batch_done_o) cnt_q <= '0;
    else if (fire)         cnt_q <= cnt_q + CW'(1);
  end

  // A request, once raised, waits for acceptance.
  p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o);

  // Every new batch begins from an empty count.
  p_batch_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> cnt_q == '0);

endmodule

// File: rtl/rdcal_dlyreg.sv
module rdcal_dlyreg #(
  parameter int                          NPHASE  = 2,
  parameter int                          DLY_W   = 3,
  parameter int                          PH_W    = 1,
  parameter logic [NPHASE*DLY_W-1:0]     DEF_DLY = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [PH_W-1:0]           wr_ph_i,
  input  logic [DLY_W-1:0]          wr_val_i,
  input  logic                      commit_en_i,
  input  logic [NPHASE*DLY_W-1:0]   commit_vec_i,
  input  logic                      restore_en_i,
  output logic [NPHASE*DLY_W-1:0]   dly_o
);

  for (genvar p = 0; p < NPHASE; p++) begin : g_ph
    logic [DLY_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q <= DEF_DLY[p*DLY_W +: DLY_W];
      else if (restore_en_i)
        code_q <= DEF_DLY[p*DLY_W +: DLY_W];
      else if (commit_en_i)
        code_q <= commit_vec_i[p*DLY_W +: DLY_W];
      else if (wr_en_i && wr_ph_i == PH_W'(p))
        code_q <= wr_val_i;
    end

    assign dly_o[p*DLY_W +: DLY_W] = code_q;
  end

endmodule

// File: rtl/rdcal_ctrl.sv
module rdcal_ctrl
  import rdcal_pkg::*;
#(
  parameter int NPHASE = 2,
  parameter int DLY_W  = 3,
  parameter int PH_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      batch_done_i,
  input  logic [NPHASE-1:0]         bd_i,
  output logic                      rd_go_o,
  output logic                      bd_clr_o,
  output logic                      wr_en_o,
  output logic [PH_W-1:0]           wr_ph_o,
  output logic [DLY_W-1:0]          wr_val_o,
  output logic                      commit_en_o,
  output logic [NPHASE*DLY_W-1:0]   commit_vec_o,
  output logic                      restore_en_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [1:0]                err_o
);
  localparam logic [DLY_W-1:0] MAXD    = '1;
  localparam logic [PH_W-1:0]  LAST_PH = PH_W'(NPHASE - 1);

  cal_state_t       state_q;
  logic             kind_q;     // 0: minimum search, 1: maximum search
  logic [PH_W-1:0]  ph_q;
  logic [DLY_W-1:0] trial_q;
  logic [DLY_W-1:0] min_q [NPHASE];
  logic [DLY_W-1:0] max_q [NPHASE];
  logic [1:0]       err_q;

  // Named internal events
  logic accept, hit, at_top, min_found, max_found, sweep_fail;

  always_comb begin
    accept     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    hit        = bd_i[ph_q];
    at_top     = (trial_q == MAXD);
    min_found  = (state_q == ST_SAMPLE) && !kind_q && hit;
    max_found  = (state_q == ST_SAMPLE) &&  kind_q && !hit;
    sweep_fail = (state_q == ST_SAMPLE) && at_top && (kind_q ? hit : !hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= 1'b0;
      ph_q    <= '0;
      trial_q <= '0;
      err_q   <= ERR_NONE;
      for (int p = 0; p < NPHASE; p++) begin
        min_q[p] <= '0;
        max_q[p] <= MAXD;
      end
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            kind_q  <= 1'b0;
            ph_q    <= '0;
            trial_q <= '0;
            err_q   <= ERR_NONE;
            for (int p = 0; p < NPHASE; p++) max_q[p] <= MAXD;
            state_q <= ST_LOAD;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_LOAD:  state_q <= ST_CLEAR;
        ST_CLEAR: state_q <= ST_READ;
        ST_READ:  if (batch_done_i) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (sweep_fail) begin
            err_q   <= ERR_DLY_MAX;
            state_q <= ST_DONE;
          end else if (min_found) begin
            min_q[ph_q] <= trial_q;
            if (ph_q == LAST_PH) begin
              kind_q  <= 1'b1;
              ph_q    <= '0;
              state_q <= ST_NEXT;
            end else begin
              ph_q    <= ph_q + PH_W'(1);
              trial_q <= '0;
              state_q <= ST_LOAD;
            end
          end else if (max_found) begin
            max_q[ph_q] <= trial_q - DLY_W'(1);
            if (ph_q == LAST_PH) begin
              state_q <= ST_FINISH;
            end else begin
              ph_q    <= ph_q + PH_W'(1);
              state_q <= ST_NEXT;
            end
          end else begin
            trial_q <= trial_q + DLY_W'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_NEXT: begin
          // A phase whose minimum is already the top code keeps max = top.
          if (min_q[ph_q] == MAXD) begin
            if (ph_q == LAST_PH) state_q <= ST_FINISH;
            else                 ph_q    <= ph_q + PH_W'(1);
          end else begin
            trial_q <= min_q[ph_q] + DLY_W'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_FINISH: state_q <= ST_DONE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPHASE; p++) begin : g_mid
    logic [7:0] centre;
    assign centre = win_centre(8'(min_q[p]), 8'(max_q[p]));
    assign commit_vec_o[p*DLY_W +: DLY_W] = centre[DLY_W-1:0];
  end

  assign rd_go_o      = (state_q == ST_READ);
  assign bd_clr_o     = (state_q == ST_CLEAR);
  assign wr_en_o      = (state_q == ST_LOAD);
  assign wr_ph_o      = ph_q;
  assign wr_val_o     = trial_q;
  assign commit_en_o  = (state_q == ST_FINISH);
  assign restore_en_o = sweep_fail;
  assign busy_o       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = err_q;

  // Maximum trials always lie above the recorded minimum.
  p_max_above_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE && kind_q) |-> trial_q > min_q[ph_q]);

  p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == ERR_NONE || err_o == ERR_DLY_MAX));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q != ST_SAMPLE && state_q != ST_NEXT)
      |=> $stable(ph_q) && $stable(kind_q));

endmodule

// File: rtl/rdcal_engine.sv
module rdcal_engine #(
  parameter int                        NPHASE  = 2,
  parameter int                        DLY_W   = 3,
  parameter int                        READS   = 128,
  parameter logic [NPHASE*DLY_W-1:0]   DEF_DLY = {3'd5, 3'd1}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [1:0]                err_o,
  output logic                      sw_ctrl_o,
  output logic                      rd_valid_o,
  input  logic                      rd_ready_i,
  input  logic [NPHASE-1:0]         bd_i,
  output logic                      bd_clr_o,
  output logic [NPHASE*DLY_W-1:0]   dly_o
);
  localparam int PH_W = (NPHASE > 1) ? $clog2(NPHASE) : 1;

  logic                    rd_go, batch_done;
  logic                    wr_en, commit_en, restore_en;
  logic [PH_W-1:0]         wr_ph;
  logic [DLY_W-1:0]        wr_val;
  logic [NPHASE*DLY_W-1:0] commit_vec;

  rdcal_ctrl #(.NPHASE(NPHASE), .DLY_W(DLY_W), .PH_W(PH_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .batch_done_i (batch_done),
    .bd_i         (bd_i),
    .rd_go_o      (rd_go),
    .bd_clr_o     (bd_clr_o),
    .wr_en_o      (wr_en),
    .wr_ph_o      (wr_ph),
    .wr_val_o     (wr_val),
    .commit_en_o  (commit_en),
    .commit_vec_o (commit_vec),
    .restore_en_o (restore_en),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  rdcal_reader #(.READS(READS)) u_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (rd_go),
    .rd_ready_i   (rd_ready_i),
    .rd_valid_o   (rd_valid_o),
    .batch_done_o (batch_done)
  );

  rdcal_dlyreg #(.NPHASE(NPHASE), .DLY_W(DLY_W), .PH_W(PH_W), .DEF_DLY(DEF_DLY)) u_dly (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_ph_i      (wr_ph),
    .wr_val_i     (wr_val),
    .commit_en_i  (commit_en),
    .commit_vec_i (commit_vec),
    .restore_en_i (restore_en),
    .dly_o        (dly_o)
  );

  assign sw_ctrl_o = busy_o;

  // Delay codes are frozen while a read batch is in flight.
  p_dly_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $stable(dly_o));

  // A batch is always preceded by a flag clear.
  p_clear_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(bd_clr_o));

  p_defaults_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd2) |-> dly_o == DEF_DLY);

  p_sw_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sw_ctrl_o);

endmodule

// File: tb/rdcal_engine_test.sv
module rdcal_engine_test;
  localparam int NPH = 2;
  localparam int DW  = 3;
  localparam int NRD = 128;
  localparam int DEF0 = 1;
  localparam int DEF1 = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             busy_o, done_o, sw_ctrl_o, rd_valid_o, bd_clr_o;
  logic [1:0]       err_o;
  logic             rd_ready_i;
  logic [NPH-1:0]   bd_i = '0;
  logic [NPH*DW-1:0] dly_o;

  rdcal_engine #(.NPHASE(NPH), .DLY_W(DW), .READS(NRD),
                 .DEF_DLY({3'(DEF1), 3'(DEF0)})) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .sw_ctrl_o(sw_ctrl_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .bd_i(bd_i),
    .bd_clr_o(bd_clr_o), .dly_o(dly_o));

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- PHY / memory model ----------------
  int win_lo [NPH];
  int win_hi [NPH];
  logic [7:0] lfsr = 8'hA5;
  assign rd_ready_i = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    #2 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  function automatic logic [NPH-1:0] pass_mask(input logic [NPH*DW-1:0] d);
    logic [NPH-1:0] m;
    for (int p = 0; p < NPH; p++) begin
      int v;
      v = int'(d[p*DW +: DW]);
      m[p] = (v >= win_lo[p]) && (v <= win_hi[p]);
    end
    return m;
  endfunction

  always @(posedge clk) begin
    if (bd_clr_o) bd_i <= '0;
    else if (rd_valid_o && rd_ready_i) bd_i <= bd_i | pass_mask(dly_o);
  end

  // ---------------- scoreboard ----------------
  typedef struct { int ph; int d; } trial_t;
  typedef struct { int err; int d0; int d1; } res_t;
  trial_t q_trial[$];
  res_t   q_res[$];

  // Expected sweep, written from the requirement text.
  task automatic build_plan(input int l0, input int h0, input int l1, input int h1);
    int lo[NPH];
    int hi[NPH];
    int mid[NPH];
    bit bad;
    res_t r;
    lo[0] = l0; hi[0] = h0; lo[1] = l1; hi[1] = h1;
    win_lo[0] = l0; win_hi[0] = h0; win_lo[1] = l1; win_hi[1] = h1;
    bad = 1'b0;
    // R3: minimum searches, phase 0 then phase 1 (R5)
    for (int p = 0; p < NPH && !bad; p++) begin
      if (lo[p] > hi[p]) begin
        for (int d = 0; d < 8; d++) q_trial.push_back('{p, d});
        bad = 1'b1;
      end else begin
        for (int d = 0; d <= lo[p]; d++) q_trial.push_back('{p, d});
      end
    end
    // R4: maximum searches
    for (int p = 0; p < NPH && !bad; p++) begin
      if (lo[p] == 7) begin
        mid[p] = 7;
      end else begin
        for (int d = lo[p] + 1; d <= hi[p] + 1 && d <= 7; d++) q_trial.push_back('{p, d});
        if (hi[p] == 7) bad = 1'b1;
        else mid[p] = (lo[p] + hi[p]) / 2;
      end
    end
    if (bad) r = '{2, DEF0, DEF1};
    else     r = '{0, mid[0], mid[1]};
    q_res.push_back(r);
  endtask

  int  done_seen = 0;
  int  rd_count  = 0;
  bit  batch_open = 1'b0;
  bit  prev_v = 1'b0, prev_r = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !prev_r) chk("R11 request held until accepted", int'(rd_valid_o), 1);
      if (prev_done) chk("R8 done lasts one cycle", int'(done_o), 0);

      if (bd_clr_o || done_o) begin
        if (batch_open) chk("R2 reads per trial", rd_count, NRD);
        batch_open = bd_clr_o;
        rd_count   = 0;
      end

      if (bd_clr_o) begin
        chk("R10 control held during sweep", int'(sw_ctrl_o), 1);
        if (q_trial.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 extra trial: actual=%0d expected=none", int'(dly_o));
        end else begin
          trial_t t;
          t = q_trial.pop_front();
          chk($sformatf("R2/R3/R4/R5 trial code phase %0d", t.ph),
              int'(dly_o[t.ph*DW +: DW]), t.d);
        end
      end

      if (done_o) begin
        done_seen++;
        chk("R8 busy low at done", int'(busy_o), 0);
        chk("R10 control released at done", int'(sw_ctrl_o), 0);
        if (q_res.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected done: actual=1 expected=0");
        end else begin
          res_t r;
          r = q_res.pop_front();
          chk("R6/R7 result code", int'(err_o), r.err);
          chk("R6/R7 phase 0 code", int'(dly_o[0 +: DW]), r.d0);
          chk("R6/R7 phase 1 code", int'(dly_o[DW +: DW]), r.d1);
        end
      end

      if (rd_valid_o && rd_ready_i) rd_count++;
      prev_v    = rd_valid_o;
      prev_r    = rd_ready_i;
      prev_done = done_o;
    end
  end

  // ---------------- driver ----------------
  task automatic run(input int l0, input int h0, input int l1, input int h1, input bit poke);
    int n0;
    build_plan(l0, h0, l1, h1);
    n0 = done_seen;
    @(posedge clk); #2 start_i = 1'b1;
    @(posedge clk); #2 start_i = 1'b0;
    if (poke) begin
      // R9: a start while busy must change nothing
      repeat (200) @(posedge clk);
      #2 start_i = 1'b1;
      @(posedge clk); #2 start_i = 1'b0;
    end
    wait (done_seen != n0);
    repeat (20) @(posedge clk);
    chk("R9 one done per accepted start", done_seen, n0 + 1);
    chk("R3/R5 all planned trials seen", q_trial.size(), 0);
    q_trial.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset phase 0 default", int'(dly_o[0 +: DW]), DEF0);
    chk("R1 reset phase 1 default", int'(dly_o[DW +: DW]), DEF1);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset control", int'(sw_ctrl_o), 0);
    chk("R1 reset read request", int'(rd_valid_o), 0);
    chk("R1 reset clear strobe", int'(bd_clr_o), 0);
    chk("R1 reset code", int'(err_o), 0);
    @(posedge clk); #2 rst_n = 1'b1;

    run(2, 5, 3, 6, 1'b0);   // R6 ordinary windows: 3 and 4
    run(0, 0, 4, 4, 1'b0);   // R3 bottom edge, single-code windows
    run(7, 7, 1, 6, 1'b0);   // R4 minimum at top, no max trials
    run(3, 7, 2, 3, 1'b0);   // R4/R7 error in maximum search
    run(1, 0, 2, 4, 1'b0);   // R3/R7 empty window on phase 0
    run(1, 2, 5, 4, 1'b0);   // R7 empty window on phase 1
    run(2, 5, 3, 6, 1'b1);   // R9 start poked mid-run
    run(0, 6, 6, 6, 1'b0);   // R6 wide and narrow windows: 3 and 6

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule